// File: doc/BRIEF.md
# Modem Line Control and Change Detector

This block owns the modem-control side of a serial port. It drives two handshake outputs, request-to-send and data-terminal-ready, plus a loopback enable that goes to the serial datapath. It watches four handshake inputs: ring indicate, clear-to-send, carrier detect and data-set-ready. Each input passes through a synchronizer. The block reports the synchronized levels, and it records changes on clear-to-send and carrier detect as sticky change flags that can raise an interrupt.

Software reaches the block through a small register port. A write strobe or a read strobe acts on one of four word addresses. Read data is combinational from the address, and a read strobe to the status word clears the change flags. Each of the two watched lines chooses whether only a rising edge counts or an edge in either direction counts. Each watched line has its own interrupt mask, and a summary enable gates the single interrupt request.

Register map, data bits beyond those listed read back as written:
- address 0, line control: bit 0 RTS control, bit 1 DTR control, bit 2 loopback.
- address 1, change setup: bit 0 CTS change mask, bit 1 DCD change mask, bit 2 CTS either-edge, bit 3 DCD either-edge.
- address 2, line status (read only): bit 0 RI level, bit 1 CTS level, bit 2 DCD level, bit 3 DSR level, bit 4 CTS changed, bit 5 DCD changed.
- address 3, summary enable: bit 0.

Top module: `modem_line_ctrl`

## Requirements
- R1: `rts_pin` equals the inverse of bit 0 of address 0, and `dtr_pin` equals the inverse of bit 1. Both take effect in the cycle after the write.
- R2: `loopback_en` follows bit 2 of address 0.
- R3: Bits 3:0 of address 2 report the levels of DSR, DCD, CTS and RI (bit 3 down to bit 0) once each level has passed through SYNC_STAGES flops.
- R4: When the either-edge bit of a watched line is clear, only a rising edge of its synchronized level sets its change flag. A falling edge leaves the flag clear.
- R5: When the either-edge bit of a watched line is set, both rising and falling edges set its change flag.
- R6: A read strobe to address 2 clears both change flags. A read of any other address leaves them unchanged.
- R7: An edge that arrives in the same cycle as a status read leaves its change flag set.
- R8: `irq` is high exactly when summary enable bit 0 of address 3 is set and some change flag is set whose mask bit in address 1 is set.
- R9: After reset all registers read zero, both outputs `rts_pin` and `dtr_pin` are high, and `loopback_en` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_wr | input | 1 | write strobe |
| reg_rd | input | 1 | read strobe (clears change flags at address 2) |
| reg_addr | input | 2 | word address |
| reg_wdata | input | DATA_W | write data |
| reg_rdata | output | DATA_W | read data for reg_addr |
| ri_pin | input | 1 | ring indicate input |
| cts_pin | input | 1 | clear-to-send input |
| dcd_pin | input | 1 | carrier detect input |
| dsr_pin | input | 1 | data-set-ready input |
| rts_pin | output | 1 | request-to-send output |
| dtr_pin | output | 1 | data-terminal-ready output |
| loopback_en | output | 1 | loopback enable to the datapath |
| irq | output | 1 | change interrupt request |

## Verification
The bench builds the block with the defaults, DATA_W of 8 and SYNC_STAGES of 2. It derives its wait counts from SYNC_STAGES, so it can place a status read in exactly the cycle where a synchronized edge shows up. That timing brings the read-versus-edge collision of R7 within reach. The two-stage depth also keeps each pattern in the stimulus table to a few cycles, so a pattern can step through rising-only and either-edge lines in one pass.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam logic [1:0] ADR_LINE_CTL  = 2'd0;
  localparam logic [1:0] ADR_CHG_SETUP = 2'd1;
  localparam logic [1:0] ADR_STATUS    = 2'd2;
  localparam logic [1:0] ADR_SUM_EN    = 2'd3;

  localparam int NUM_WATCHED = 2;  // CTS, DCD

  // edge test: either direction when any_dir, else rising only
  function automatic logic edge_seen(input logic prev, input logic cur, input logic any_dir);
    return any_dir ? (prev ^ cur) : (cur & ~prev);
  endfunction

  // interrupt request from flags, masks and summary enable
  function automatic logic irq_calc(input logic [NUM_WATCHED-1:0] flags,
                                    input logic [NUM_WATCHED-1:0] masks,
                                    input logic sum_en);
    return sum_en & (|(flags & masks));
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/mdm_change_det.sv
module mdm_change_det
  import modem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic any_dir,
  input  logic clr,
  output logic edge_hit,
  output logic chg
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign edge_hit = edge_seen(prev_q, level, any_dir);

  // a new edge wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chg <= 1'b0;
    else if (edge_hit) chg <= 1'b1;
    else if (clr)      chg <= 1'b0;
  end

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> chg);  // R4
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !chg);  // R6
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg) |-> $past(edge_hit));  // R5
endmodule

// File: rtl/modem_line_ctrl.sv
module modem_line_ctrl
  import modem_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ri_pin,
  input  logic              cts_pin,
  input  logic              dcd_pin,
  input  logic              dsr_pin,
  output logic              rts_pin,
  output logic              dtr_pin,
  output logic              loopback_en,
  output logic              irq
);
  localparam int NUM_IN = 4;

  logic [DATA_W-1:0] line_ctl_q, chg_setup_q, sum_en_q;
  logic [NUM_IN-1:0] lvl;
  logic [NUM_WATCHED-1:0] watched_lvl, any_dir, flag, edge_hit, mask;
  logic status_clr;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ctl_q  <= '0;
      chg_setup_q <= '0;
      sum_en_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADR_LINE_CTL:  line_ctl_q  <= reg_wdata;
        ADR_CHG_SETUP: chg_setup_q <= reg_wdata;
        ADR_SUM_EN:    sum_en_q    <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign rts_pin     = ~line_ctl_q[0];
  assign dtr_pin     = ~line_ctl_q[1];
  assign loopback_en = line_ctl_q[2];

  // input synchronization: {dsr, dcd, cts, ri}
  mdm_sync #(.STAGES(SYNC_STAGES), .W(NUM_IN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({dsr_pin, dcd_pin, cts_pin, ri_pin}),
    .d_sync(lvl)
  );

  assign watched_lvl = {lvl[2], lvl[1]};          // {dcd, cts}
  assign mask        = chg_setup_q[1:0];
  assign any_dir     = chg_setup_q[3:2];
  assign status_clr  = reg_rd && (reg_addr == ADR_STATUS);

  for (genvar i = 0; i < NUM_WATCHED; i++) begin : g_watch
    mdm_change_det u_det (
      .clk(clk), .rst_n(rst_n),
      .level(watched_lvl[i]), .any_dir(any_dir[i]), .clr(status_clr),
      .edge_hit(edge_hit[i]), .chg(flag[i])
    );
  end

  assign irq = irq_calc(flag, mask, sum_en_q[0]);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_LINE_CTL:  reg_rdata = line_ctl_q;
      ADR_CHG_SETUP: reg_rdata = chg_setup_q;
      ADR_STATUS: begin
        reg_rdata[3:0] = lvl;
        reg_rdata[5:4] = flag;
      end
      default:       reg_rdata = sum_en_q;
    endcase
  end

  AST_RTS_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_LINE_CTL) |=> (rts_pin == !$past(reg_wdata[0])));  // R1
  AST_DTR_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_LINE_CTL) |=> (dtr_pin == !$past(reg_wdata[1])));  // R1
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_en_q[0] |-> !irq);  // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flag));  // R8
  AST_KEEP_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && (|edge_hit)) |=> (|flag));  // R7
endmodule

// File: tb/test_modem_line_ctrl.sv
module test_modem_line_ctrl;
  localparam int DATA_W = 8;
  localparam int SYNC   = 2;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [DATA_W-1:0] reg_wdata = 0, reg_rdata;
  logic ri_pin = 0, cts_pin = 0, dcd_pin = 0, dsr_pin = 0;
  logic rts_pin, dtr_pin, loopback_en, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  modem_line_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) i_modem_line_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ri_pin(ri_pin), .cts_pin(cts_pin),
    .dcd_pin(dcd_pin), .dsr_pin(dsr_pin), .rts_pin(rts_pin), .dtr_pin(dtr_pin),
    .loopback_en(loopback_en), .irq(irq));

  // pattern table: {pins dsr,dcd,cts,ri ; expected status bits 5:0}
  // setup: CTS rising only, DCD either edge; every check reads (and clears)
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {4'b0010, 6'b01_0010}, {4'b0000, 6'b00_0000},
    {4'b0100, 6'b10_0100}, {4'b0000, 6'b10_0000},
    {4'b1001, 6'b00_1001}, {4'b0110, 6'b11_0110},
    {4'b1111, 6'b00_1111}, {4'b0000, 6'b10_0000}};

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pins(input logic [3:0] p);
    @(negedge clk); {dsr_pin, dcd_pin, cts_pin, ri_pin} = p;
    repeat (SYNC + 2) @(posedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 pins", {6'b0, rts_pin, dtr_pin}, 8'h03);
    check("R9 loop/irq", {6'b0, loopback_en, irq}, 8'h00);
    rst_n = 1;
    rd(2'd0, d); check("R9 line ctl", d, 8'h00);
    rd(2'd2, d); check("R9 status", d, 8'h00);

    // R1 / R2
    wr(2'd0, 8'h01); #1
    check("R1 rts low dtr high", {6'b0, rts_pin, dtr_pin}, 8'h01);
    wr(2'd0, 8'h06); #1
    check("R1 dtr low", {6'b0, rts_pin, dtr_pin}, 8'h02);
    check("R2 loopback on", {7'b0, loopback_en}, 8'h01);
    wr(2'd0, 8'h00); #1
    check("R2 loopback off", {7'b0, loopback_en}, 8'h00);

    // table: R3 levels, R4 rising only on CTS, R5 either edge on DCD, R6 clear
    wr(2'd1, 8'h08);
    for (int i = 0; i < NV; i++) begin
      pins(VEC[i][9:6]);
      rd(2'd2, d);
      check($sformatf("R3/R4/R5 vector %0d", i), d, {2'b0, VEC[i][5:0]});
    end
    rd(2'd2, d); check("R6 cleared after read", d, 8'h00);

    // R6: read of another address keeps flags
    pins(4'b0010);
    rd(2'd1, d);
    rd(2'd2, d); check("R6 other read keeps flag", d, 8'h12);

    // R7: edge in same cycle as status read
    pins(4'b0000);
    rd(2'd2, d);
    @(negedge clk); cts_pin = 1;
    repeat (SYNC) @(posedge clk);
    @(negedge clk); reg_rd = 1; reg_addr = 2'd2;
    @(negedge clk); reg_rd = 0;
    rd(2'd2, d); check("R7 flag survives collision", d, 8'h12);

    // R8 interrupt gating
    pins(4'b0000); rd(2'd2, d);
    wr(2'd1, 8'h09);              // CTS mask on, DCD either edge, DCD mask off
    wr(2'd3, 8'h01);
    pins(4'b0100);                // DCD change, masked
    check("R8 masked line no irq", {7'b0, irq}, 8'h00);
    pins(4'b0110);                // CTS rises
    check("R8 irq raised", {7'b0, irq}, 8'h01);
    wr(2'd3, 8'h00); #1
    check("R8 summary off", {7'b0, irq}, 8'h00);
    wr(2'd3, 8'h01); #1
    check("R8 summary back on", {7'b0, irq}, 8'h01);
    rd(2'd2, d); #1
    check("R8 irq drops after read", {7'b0, irq}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule